// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block translates virtual addresses to physical addresses for 4 KB pages. It holds a small set of page mappings, and any mapping may sit in any slot. A lookup compares the virtual page number against every valid slot in parallel. The hit or miss verdict and the physical address appear combinationally in the same cycle as the request. The low 12 address bits pass through untranslated. A miss is flagged in that same cycle, so the pipeline can hold back its result. A handler outside the block then loads the mapping through the refill port and retries the access.

Every slot carries two usage flags. The "touched" flag is set by any hit. The "modified" flag is set by a write hit. A single strobe clears the touched flags of all slots, so software can approximate recency. A flush strobe invalidates every slot at once. A refill goes to one of three places, in this order of preference:
- the slot already holding the same virtual page, which is overwritten;
- otherwise the lowest-numbered free slot;
- otherwise a victim chosen by a rotating pointer.

Top module: `xlate_cache`

## Requirements
- R1: While reset is asserted and after its release, no slot is valid: every lookup reports miss (lkMiss=1, lkHit=0).
- R2: A lookup (lkValid=1) whose address bits [31:12] equal the page number of a valid slot reports lkHit=1, lkMiss=0 in the same cycle. In that cycle lkPhysAddr is that slot's physical page number in bits [31:12], with lkAddr[11:0] copied unchanged into bits [11:0].
- R3: A lookup matching no valid slot reports lkMiss=1, lkHit=0 and lkPhysAddr=0 in the same cycle, and leaves every slot unchanged.
- R4: lkRef and lkDirty show the hit slot's flags as stored before the current access. A hit sets the slot's touched flag from the next cycle on.
- R5: A hit with lkWrite=1 sets the slot's modified flag from the next cycle on. A hit with lkWrite=0 leaves that flag unchanged.
- R6: refClear=1 clears the touched flag of every slot at the next edge. A hit in the same cycle still leaves its own slot's touched flag set.
- R7: A refill with fillValid=1 stores fillVpn, fillPpn, fillRef and fillDirty. A later lookup of that page hits with that physical page and reports those flags.
- R8: While free slots remain, refills take the lowest-numbered free slot, so the number of distinct pages held is limited only by the slot count (16).
- R9: With every slot valid, a refill of a new page evicts the slot named by a rotating pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, only when it is used.
- R10: A refill of a page already present overwrites that slot. It does not take a second slot and does not advance the eviction pointer.
- R11: flush=1 invalidates every slot at the next edge. A refill in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 32 | Virtual address to translate |
| lkWrite | input | 1 | Lookup is a store access |
| lkHit | output | 1 | Lookup found a valid mapping |
| lkMiss | output | 1 | Lookup found no mapping; retry after refill |
| lkPhysAddr | output | 32 | Translated address, zero on miss |
| lkRef | output | 1 | Touched flag of the hit slot before this access |
| lkDirty | output | 1 | Modified flag of the hit slot before this access |
| fillValid | input | 1 | Refill request |
| fillVpn | input | 20 | Virtual page number to load |
| fillPpn | input | 20 | Physical page number to load |
| fillRef | input | 1 | Initial touched flag |
| fillDirty | input | 1 | Initial modified flag |
| refClear | input | 1 | Clear every touched flag |
| flush | input | 1 | Invalidate every slot |

## Verification
The touched-flag clear and a lookup hit can land in the same cycle. One clears every slot's flag while the other sets one slot's flag. The bench loads two pages with the touched flag set. In a single cycle it raises refClear and looks up one of them. It then looks up both pages: the accessed page must still read as touched and the other as clear. The same approach covers a flush raised together with a refill: every page, including the one being refilled, must miss afterwards.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  // Index width that covers the largest supported slot count (512).
  localparam int STROBE_IDX_W = 9;

  typedef struct packed {
    logic                    fillWe;
    logic [STROBE_IDX_W-1:0] fillIdx;
    logic                    accWe;
    logic [STROBE_IDX_W-1:0] accIdx;
    logic                    accDirty;
    logic                    clrRef;
    logic                    clrValid;
  } xlate_strobe_t;
endpackage

// File: rtl/xlate_datapath.sv
module xlate_datapath
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  xlate_strobe_t       strobe,
  input  logic [VPN_W-1:0]    lkVpn,
  input  logic [VPN_W-1:0]    fillVpn,
  input  logic [PPN_W-1:0]    fillPpn,
  input  logic                fillRef,
  input  logic                fillDirty,
  output logic [ENTRIES-1:0]  hitVec,
  output logic [ENTRIES-1:0]  fillHitVec,
  output logic [ENTRIES-1:0]  validVec,
  output logic [PPN_W-1:0]    hitPpn,
  output logic                hitRef,
  output logic                hitDirty
);
  logic [ENTRIES-1:0] validQ, refQ, dirtyQ;
  logic [VPN_W-1:0]   vpnQ [ENTRIES];
  logic [PPN_W-1:0]   ppnQ [ENTRIES];

  // One comparator pair per slot: lookup side and refill side.
  for (genvar g = 0; g < ENTRIES; g++) begin : gSlot
    assign hitVec[g]     = validQ[g] && (vpnQ[g] == lkVpn);
    assign fillHitVec[g] = validQ[g] && (vpnQ[g] == fillVpn);
  end

  assign validVec = validQ;

  // One-hot read mux: OR of masked slot contents.
  always_comb begin
    hitPpn   = '0;
    hitRef   = 1'b0;
    hitDirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) begin
        hitPpn   = hitPpn | ppnQ[i];
        hitRef   = hitRef | refQ[i];
        hitDirty = hitDirty | dirtyQ[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      refQ   <= '0;
      dirtyQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpnQ[i] <= '0;
        ppnQ[i] <= '0;
      end
    end else if (strobe.clrValid) begin
      validQ <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.fillWe && strobe.fillIdx == STROBE_IDX_W'(i)) begin
          validQ[i] <= 1'b1;
          vpnQ[i]   <= fillVpn;
          ppnQ[i]   <= fillPpn;
          refQ[i]   <= fillRef;
          dirtyQ[i] <= fillDirty;
        end else begin
          if (strobe.clrRef) refQ[i] <= 1'b0;
          // An access in the clearing cycle still marks its own slot.
          if (strobe.accWe && strobe.accIdx == STROBE_IDX_W'(i)) begin
            refQ[i] <= 1'b1;
            if (strobe.accDirty) dirtyQ[i] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lkValid,
  input  logic               lkWrite,
  input  logic               fillValid,
  input  logic               refClear,
  input  logic               flush,
  input  logic [ENTRIES-1:0] hitVec,
  input  logic [ENTRIES-1:0] fillHitVec,
  input  logic [ENTRIES-1:0] validVec,
  output xlate_strobe_t      strobe
);
  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] hitIdx, matchIdx, freeIdx, fillIdx;
  logic             anyHit, anyMatch, allValid, useVictim;

  always_comb begin
    hitIdx   = '0;
    matchIdx = '0;
    freeIdx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i])     hitIdx   = IDX_W'(i);
      if (fillHitVec[i]) matchIdx = IDX_W'(i);
    end
    // Scan downwards so the lowest free slot wins.
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) freeIdx = IDX_W'(i);
    end
  end

  assign anyHit    = |hitVec;
  assign anyMatch  = |fillHitVec;
  assign allValid  = &validVec;
  assign useVictim = fillValid && !flush && !anyMatch && allValid;

  always_comb begin
    if (anyMatch)      fillIdx = matchIdx;
    else if (!allValid) fillIdx = freeIdx;
    else               fillIdx = rrPtr;
  end

  always_comb begin
    strobe          = '0;
    strobe.fillWe   = fillValid && !flush;
    strobe.fillIdx  = STROBE_IDX_W'(fillIdx);
    strobe.accWe    = lkValid && anyHit;
    strobe.accIdx   = STROBE_IDX_W'(hitIdx);
    strobe.accDirty = lkWrite;
    strobe.clrRef   = refClear;
    strobe.clrValid = flush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rrPtr <= '0;
    else if (useVictim)
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
  end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic [VA_W-1:0]  lkAddr,
  input  logic             lkWrite,
  output logic             lkHit,
  output logic             lkMiss,
  output logic [PA_W-1:0]  lkPhysAddr,
  output logic             lkRef,
  output logic             lkDirty,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic             fillRef,
  input  logic             fillDirty,
  input  logic             refClear,
  input  logic             flush
);
  xlate_strobe_t      strobe;
  logic [ENTRIES-1:0] hitVec, fillHitVec, validVec;
  logic [PPN_W-1:0]   hitPpn;
  logic               hitRef, hitDirty, found;

  xlate_datapath #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lkVpn(lkAddr[VA_W-1:OFF_W]), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .fillRef(fillRef), .fillDirty(fillDirty),
    .hitVec(hitVec), .fillHitVec(fillHitVec), .validVec(validVec),
    .hitPpn(hitPpn), .hitRef(hitRef), .hitDirty(hitDirty)
  );

  xlate_ctrl #(.ENTRIES(ENTRIES)) uCtl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkWrite(lkWrite),
    .fillValid(fillValid), .refClear(refClear), .flush(flush),
    .hitVec(hitVec), .fillHitVec(fillHitVec), .validVec(validVec),
    .strobe(strobe)
  );

  assign found      = |hitVec;
  assign lkHit      = lkValid && found;
  assign lkMiss     = lkValid && !found;
  assign lkPhysAddr = lkHit ? {hitPpn, lkAddr[OFF_W-1:0]} : '0;
  assign lkRef      = lkHit && hitRef;
  assign lkDirty    = lkHit && hitDirty;
endmodule

// File: rtl/xlate_checker.sv
module xlate_checker #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int OFF_W = 12
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   lkValid,
  input logic [VPN_W+OFF_W-1:0] lkAddr,
  input logic                   lkWrite,
  input logic                   lkHit,
  input logic                   lkMiss,
  input logic [PPN_W+OFF_W-1:0] lkPhysAddr,
  input logic                   lkRef,
  input logic                   lkDirty,
  input logic                   fillValid,
  input logic [VPN_W-1:0]       fillVpn,
  input logic [PPN_W-1:0]       fillPpn,
  input logic                   refClear,
  input logic                   flush
);
  // R2: the page offset is never altered by translation.
  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> lkPhysAddr[OFF_W-1:0] == lkAddr[OFF_W-1:0]);

  // R3: no verdict without a request, and a miss yields a zero address.
  a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    lkMiss |-> (lkPhysAddr == '0 && !lkHit && lkValid));

  // R7: a page loaded in one cycle translates to its frame in the next.
  a_r7_fill_visible: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !flush) ##1 (lkValid && lkAddr[VPN_W+OFF_W-1:OFF_W] == $past(fillVpn))
    |-> (lkHit && lkPhysAddr[PPN_W+OFF_W-1:OFF_W] == $past(fillPpn)));

  // R4: after a hit, the same page reads back as touched.
  a_r4_ref_after_hit: assert property (@(posedge clk) disable iff (!rstN)
    (lkHit && !fillValid && !flush) ##1
    (lkValid && lkAddr[VPN_W+OFF_W-1:OFF_W] == $past(lkAddr[VPN_W+OFF_W-1:OFF_W]))
    |-> lkRef);

  // R5: after a write hit, the same page reads back as modified.
  a_r5_dirty_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (lkHit && lkWrite && !fillValid && !flush) ##1
    (lkValid && lkAddr[VPN_W+OFF_W-1:OFF_W] == $past(lkAddr[VPN_W+OFF_W-1:OFF_W]))
    |-> lkDirty);

  // R6: a clear with no access leaves no slot touched.
  a_r6_clear_ref: assert property (@(posedge clk) disable iff (!rstN)
    (refClear && !lkValid && !fillValid && !flush) |=> !lkRef);

  // R11: nothing hits right after a flush.
  a_r11_flush_empty: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !lkHit);
endmodule

bind xlate_cache xlate_checker #(.VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) uChk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkAddr(lkAddr), .lkWrite(lkWrite),
  .lkHit(lkHit), .lkMiss(lkMiss), .lkPhysAddr(lkPhysAddr), .lkRef(lkRef),
  .lkDirty(lkDirty), .fillValid(fillValid), .fillVpn(fillVpn), .fillPpn(fillPpn),
  .refClear(refClear), .flush(flush)
);

// File: tb/sim_xlate_cache.sv
`timescale 1ns/1ps
module sim_xlate_cache;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0, lkWrite = 1'b0;
  logic [31:0] lkAddr = '0;
  logic        lkHit, lkMiss, lkRef, lkDirty;
  logic [31:0] lkPhysAddr;
  logic        fillValid = 1'b0, fillRef = 1'b0, fillDirty = 1'b0;
  logic [19:0] fillVpn = '0, fillPpn = '0;
  logic        refClear = 1'b0, flush = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic        sHit, sMiss, sRef, sDirty;
  logic [31:0] sPa;

  always #2.5 clk = ~clk;

  xlate_cache u0 (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkAddr(lkAddr), .lkWrite(lkWrite),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkPhysAddr(lkPhysAddr), .lkRef(lkRef),
    .lkDirty(lkDirty), .fillValid(fillValid), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .fillRef(fillRef), .fillDirty(fillDirty), .refClear(refClear), .flush(flush)
  );

  // Vector: {addr[31:0], write, expHit, expPpn[19:0]}
  localparam logic [53:0] VECS [8] = '{
    {32'h12345678, 1'b0, 1'b1, 20'hABCDE},
    {32'h00000FFF, 1'b0, 1'b1, 20'h00001},
    {32'hFFFFF000, 1'b0, 1'b1, 20'h7F00F},
    {32'h0A0A0ABC, 1'b1, 1'b1, 20'h55555},
    {32'h12346000, 1'b0, 1'b0, 20'h00000},
    {32'h0A0A1123, 1'b1, 1'b0, 20'h00000},
    {32'hFFFFEFFF, 1'b0, 1'b0, 20'h00000},
    {32'h12345001, 1'b0, 1'b1, 20'hABCDE}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setIdle();
    lkValid = 1'b0; lkWrite = 1'b0; lkAddr = '0;
    fillValid = 1'b0; fillVpn = '0; fillPpn = '0; fillRef = 1'b0; fillDirty = 1'b0;
    refClear = 1'b0; flush = 1'b0;
  endtask

  task automatic finishCycle();
    @(posedge clk);
    #1;
    setIdle();
  endtask

  task automatic look(input logic [31:0] a, input logic w, input logic clr);
    @(negedge clk);
    setIdle();
    lkValid = 1'b1; lkAddr = a; lkWrite = w; refClear = clr;
    #1;
    sHit = lkHit; sMiss = lkMiss; sPa = lkPhysAddr; sRef = lkRef; sDirty = lkDirty;
    finishCycle();
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p,
                      input logic r, input logic d, input logic fl);
    @(negedge clk);
    setIdle();
    fillValid = 1'b1; fillVpn = v; fillPpn = p; fillRef = r; fillDirty = d; flush = fl;
    finishCycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: lookup while reset is held
    lkValid = 1'b1; lkAddr = 32'h12345678;
    #3;
    chk("R1 miss in reset", {31'b0, lkMiss}, 32'd1);
    chk("R1 no hit in reset", {31'b0, lkHit}, 32'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    setIdle();
    look(32'h12345678, 1'b0, 1'b0);
    chk("R1 miss after reset", {31'b0, sMiss}, 32'd1);

    // R2/R3: table of lookups against four mappings
    fill(20'h12345, 20'hABCDE, 1'b0, 1'b0, 1'b0);
    fill(20'h00000, 20'h00001, 1'b0, 1'b0, 1'b0);
    fill(20'hFFFFF, 20'h7F00F, 1'b0, 1'b0, 1'b0);
    fill(20'h0A0A0, 20'h55555, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] a;
      logic [31:0] expPa;
      a = VECS[k][53:22];
      expPa = VECS[k][20] ? {VECS[k][19:0], a[11:0]} : 32'h0;
      look(a, VECS[k][21], 1'b0);
      chk(VECS[k][20] ? "R2 hit flag" : "R3 hit flag", {31'b0, sHit}, {31'b0, VECS[k][20]});
      chk(VECS[k][20] ? "R2 miss flag" : "R3 miss flag", {31'b0, sMiss}, {31'b0, ~VECS[k][20]});
      chk(VECS[k][20] ? "R2 phys addr" : "R3 zero addr", sPa, expPa);
    end
    // R3: misses left a page untouched (0x0A0A1 still misses; 0xFFFFF ref from hit only)
    look(32'h0A0A1000, 1'b0, 1'b0);
    chk("R3 miss leaves no mapping", {31'b0, sHit}, 32'd0);

    // R4/R5: status flags on a fresh page
    fill(20'h44444, 20'h00444, 1'b0, 1'b0, 1'b0);
    look(32'h44444010, 1'b0, 1'b0);
    chk("R4 first ref clear", {31'b0, sRef}, 32'd0);
    look(32'h44444020, 1'b0, 1'b0);
    chk("R4 ref set after hit", {31'b0, sRef}, 32'd1);
    chk("R5 read keeps clean", {31'b0, sDirty}, 32'd0);
    look(32'h44444030, 1'b1, 1'b0);
    chk("R5 dirty before write", {31'b0, sDirty}, 32'd0);
    look(32'h44444040, 1'b0, 1'b0);
    chk("R5 dirty after write", {31'b0, sDirty}, 32'd1);

    // R6: clear together with a hit
    fill(20'h66660, 20'h00660, 1'b1, 1'b0, 1'b0);
    fill(20'h66661, 20'h00661, 1'b1, 1'b0, 1'b0);
    look(32'h66660000, 1'b0, 1'b1);
    chk("R6 ref before clear", {31'b0, sRef}, 32'd1);
    look(32'h66660000, 1'b0, 1'b0);
    chk("R6 accessed keeps ref", {31'b0, sRef}, 32'd1);
    look(32'h66661000, 1'b0, 1'b0);
    chk("R6 other ref cleared", {31'b0, sRef}, 32'd0);

    // R7: refill loads status flags
    fill(20'h77777, 20'h12321, 1'b1, 1'b1, 1'b0);
    look(32'h77777ABC, 1'b0, 1'b0);
    chk("R7 filled frame", sPa, 32'h12321ABC);
    chk("R7 filled ref", {31'b0, sRef}, 32'd1);
    chk("R7 filled dirty", {31'b0, sDirty}, 32'd1);

    // R11: flush wins over a same-cycle refill
    fill(20'h88888, 20'h00888, 1'b0, 1'b0, 1'b1);
    look(32'h88888000, 1'b0, 1'b0);
    chk("R11 refill dropped", {31'b0, sHit}, 32'd0);
    look(32'h12345000, 1'b0, 1'b0);
    chk("R11 old page gone", {31'b0, sMiss}, 32'd1);
    look(32'h77777000, 1'b0, 1'b0);
    chk("R11 newest page gone", {31'b0, sMiss}, 32'd1);

    // R8: sixteen distinct pages all held
    for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) begin
      look({20'h00100 + 20'(i), 12'h5A5}, 1'b0, 1'b0);
      chk("R8 all slots hold", sPa, {20'h00200 + 20'(i), 12'h5A5});
    end

    // R9: full table evicts slot 0 first
    fill(20'h00300, 20'h00900, 1'b0, 1'b0, 1'b0);
    look(32'h00100000, 1'b0, 1'b0);
    chk("R9 first victim evicted", {31'b0, sMiss}, 32'd1);
    look(32'h00101000, 1'b0, 1'b0);
    chk("R9 next slot kept", {31'b0, sHit}, 32'd1);
    look(32'h00300000, 1'b0, 1'b0);
    chk("R9 new page held", sPa, 32'h00900000);

    // R10: refill of a present page overwrites in place
    fill(20'h00105, 20'h003AB, 1'b0, 1'b0, 1'b0);
    look(32'h00105123, 1'b0, 1'b0);
    chk("R10 overwritten frame", sPa, 32'h003AB123);
    fill(20'h00301, 20'h00901, 1'b0, 1'b0, 1'b0);
    look(32'h00101000, 1'b0, 1'b0);
    chk("R10 pointer not advanced", {31'b0, sMiss}, 32'd1);
    look(32'h00102000, 1'b0, 1'b0);
    chk("R10 no duplicate slot", {31'b0, sHit}, 32'd1);
    look(32'h00105000, 1'b0, 1'b0);
    chk("R10 overwrite survives", sPa, 32'h003AB000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule